// File: doc/BRIEF.md
# Video Processor Host Port

This block is the processor-facing front end of a tile and bitmap video display processor. The CPU reaches it through two byte-wide ports that share one strobe bus: a control port and a data port. Writes to the control port arrive as byte pairs. The first byte carries a value or the low address bits. The second byte carries flag bits that choose one of three actions: load a configuration register, set up a VRAM write address, or set up a VRAM read address.

The data port moves bytes to and from a 17-bit VRAM space. That space is built from a 14-bit in-page address and a 3-bit page held in configuration register 14. Every data-port access advances the address. A block fill or a block copy therefore needs only one address setup. Reads are served from a read-ahead latch. The latch is refilled in the background after each read.

Toward VRAM the block issues one request at a time over a request/acknowledge handshake. `cpu_busy` is high while a request is outstanding, and CPU strobes are dropped during that time. The display side reads the configuration registers through a separate combinational select port.

Top module: `vdp_host_port`

## Requirements
- R1: After synchronous reset, all configuration registers read 0x00, `vram_req` and `cpu_busy` are low, `cpu_rdata` is 0x00, and the control sequencer expects a first byte.
- R2: A control-port pair whose second byte has bit 7 set loads the first byte into register number second[5:0]. Only numbers 0..26 and 0x20..0x2E exist. A pair that names any other number changes no register.
- R3: A write to register 14 keeps only bits 2:0 of the value. Register 14 is the page that forms VRAM address bits 16:14.
- R4: A pair whose second byte has bit 7 = 0 and bit 6 = 1 sets the address to {second[5:0], first} and issues no VRAM request.
- R5: A pair whose second byte has bits 7:6 = 00 sets the same 14-bit address. It also issues one VRAM read at {page, address}, and the acknowledged byte fills the read-ahead latch. The address does not advance.
- R6: A data-port write issues a VRAM write of the byte at {page, address}, loads the same byte into the read-ahead latch, and advances the address.
- R7: A data-port read puts the read-ahead latch on `cpu_rdata` one cycle after the strobe. It then advances the address and issues a VRAM read at the new address to refill the latch.
- R8: Advancing from in-page address 0x3FFF gives 0x0000 and raises register 14 by one, modulo 8.
- R9: Any accepted data-port access, and any accepted control-port read, returns the control sequencer to expecting a first byte.
- R10: `vram_req` stays high, with `vram_we`, `vram_addr` and `vram_wdata` unchanged, until the cycle in which `vram_ack` is high. `cpu_busy` is high exactly while a request is outstanding.
- R11: A CPU strobe that arrives while `cpu_busy` is high has no effect.
- R12: A control-port read returns 0x00 on `cpu_rdata` one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Single-cycle write strobe |
| cpu_rd | input | 1 | Single-cycle read strobe (ignored when cpu_wr is high) |
| cpu_sel_data | input | 1 | 1 selects the data port, 0 the control port |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, registered |
| cpu_busy | output | 1 | VRAM request outstanding; strobes are dropped |
| vram_req | output | 1 | VRAM request, held until acknowledged |
| vram_we | output | 1 | 1 for a write request, 0 for a read request |
| vram_addr | output | 17 | VRAM byte address {page, in-page address} |
| vram_wdata | output | 8 | Write byte |
| vram_ack | input | 1 | One-cycle acknowledge; vram_rdata is valid with it |
| vram_rdata | input | 8 | Read byte |
| cfg_rd_sel | input | 6 | Register number for the display-side read |
| cfg_rd_data | output | 8 | Selected register value (0x00 for numbers that do not exist) |

## Verification
A sequencer stuck in the wrong phase shows at once. The next register pair loads the wrong register, or turns into an address setup, and the register read port exposes this on the following cycle. A wrong address or page shows on `vram_addr` at the very next request. Carry errors therefore appear on the access that crosses 0x3FFF. A stale read-ahead latch shows on `cpu_rdata` one cycle after the next data-port read. A request that is dropped early or changes before its acknowledge shows in the per-cycle comparison of the request fields.

// File: rtl/vdp_hp_pkg.sv
package vdp_hp_pkg;

    localparam int DATA_W        = 8;
    localparam int ADDR_LO_W     = 14;
    localparam int PAGE_W        = 3;
    localparam int VADDR_W       = ADDR_LO_W + PAGE_W;
    localparam int REG_SEL_W     = 6;
    localparam int NUM_BASE_REGS = 27;
    localparam int CMD_REG_FIRST = 32;
    localparam int NUM_CMD_REGS  = 15;
    localparam int NUM_REGS      = NUM_BASE_REGS + NUM_CMD_REGS;
    localparam int PAGE_REG      = 14;
    localparam int HI_BITS_W     = ADDR_LO_W - DATA_W;

    typedef enum logic [1:0] {
        OP_NONE      = 2'd0,
        OP_REG_WRITE = 2'd1,
        OP_SET_WRITE = 2'd2,
        OP_SET_READ  = 2'd3
    } ctl_op_e;

    typedef struct packed {
        ctl_op_e                op;
        logic [REG_SEL_W-1:0]   reg_num;
        logic [DATA_W-1:0]      value;
        logic [ADDR_LO_W-1:0]   addr;
    } ctl_cmd_t;

    typedef struct packed {
        logic                   we;
        logic [VADDR_W-1:0]     addr;
        logic [DATA_W-1:0]      data;
    } vram_op_t;

    // Storage slot index -> architectural register number
    function automatic int slot_number(int idx);
        return (idx < NUM_BASE_REGS) ? idx : (idx - NUM_BASE_REGS + CMD_REG_FIRST);
    endfunction

    // Decode a completed control byte pair
    function automatic ctl_cmd_t decode_pair(logic [DATA_W-1:0] first,
                                             logic [DATA_W-1:0] second);
        ctl_cmd_t c;
        c.reg_num = second[REG_SEL_W-1:0];
        c.value   = first;
        c.addr    = {second[HI_BITS_W-1:0], first};
        if (second[7])      c.op = OP_REG_WRITE;
        else if (second[6]) c.op = OP_SET_WRITE;
        else                c.op = OP_SET_READ;
        return c;
    endfunction

endpackage

// File: rtl/vdp_ctl_seq.sv
module vdp_ctl_seq
    import vdp_hp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_acc,
    input  logic              seq_clear,
    input  logic [DATA_W-1:0] wdata,
    output ctl_cmd_t          cmd
);

    logic              second_q;
    logic [DATA_W-1:0] first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            second_q <= 1'b0;
            first_q  <= '0;
        end else if (seq_clear) begin
            second_q <= 1'b0;
        end else if (wr_acc) begin
            if (!second_q) begin
                first_q  <= wdata;
                second_q <= 1'b1;
            end else begin
                second_q <= 1'b0;
            end
        end
    end

    always_comb begin
        if (wr_acc && second_q) cmd = decode_pair(first_q, wdata);
        else                    cmd = '0;
    end

    // R9: a data access or control read leaves the sequencer at the first byte
    p_seq_clear_r9: assert property (@(posedge clk) disable iff (rst)
        seq_clear |=> !second_q);

    // R2: a lone first byte moves the sequencer to the second-byte phase
    p_first_byte_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && !seq_clear && !second_q) |=> second_q);

endmodule

// File: rtl/vdp_cfg_regs.sv
module vdp_cfg_regs
    import vdp_hp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_we,
    input  logic [REG_SEL_W-1:0] cmd_num,
    input  logic [DATA_W-1:0]    cmd_val,
    input  logic                 page_we,
    input  logic [PAGE_W-1:0]    page_val,
    input  logic [REG_SEL_W-1:0] rd_sel,
    output logic [DATA_W-1:0]    rd_data,
    output logic [PAGE_W-1:0]    page
);

    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        localparam logic [REG_SEL_W-1:0] NUM = REG_SEL_W'(slot_number(g));
        if (slot_number(g) == PAGE_REG) begin : g_page
            always_ff @(posedge clk) begin
                if (rst)                          regs_q[g] <= '0;
                else if (page_we)                 regs_q[g] <= {{(DATA_W-PAGE_W){1'b0}}, page_val};
                else if (cmd_we && cmd_num == NUM) regs_q[g] <= {{(DATA_W-PAGE_W){1'b0}}, cmd_val[PAGE_W-1:0]};
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)                          regs_q[g] <= '0;
                else if (cmd_we && cmd_num == NUM) regs_q[g] <= cmd_val;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_sel == REG_SEL_W'(slot_number(i))) rd_data = regs_q[i];
        end
    end

    assign page = regs_q[PAGE_REG][PAGE_W-1:0];

    // R3: a register write to the page register loads the masked value
    p_page_load_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && !page_we && cmd_num == REG_SEL_W'(PAGE_REG)) |=> page == $past(cmd_val[PAGE_W-1:0]));

endmodule

// File: rtl/vdp_vram_port.sv
module vdp_vram_port
    import vdp_hp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  ctl_op_e              set_op,
    input  logic [ADDR_LO_W-1:0] set_addr,
    input  logic                 data_wr,
    input  logic                 data_rd,
    input  logic                 ctl_rd,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [PAGE_W-1:0]    page,
    output logic                 page_we,
    output logic [PAGE_W-1:0]    page_val,
    output logic [DATA_W-1:0]    cpu_rdata,
    output logic                 vram_req,
    output vram_op_t             vram_op,
    input  logic                 vram_ack,
    input  logic [DATA_W-1:0]    vram_rdata
);

    logic [ADDR_LO_W-1:0] addr_q;
    logic [DATA_W-1:0]    latch_q;
    logic [DATA_W-1:0]    rdata_q;
    logic                 req_q;
    vram_op_t             op_q;
    logic [VADDR_W-1:0]   cur_full;
    logic [VADDR_W-1:0]   nxt_full;
    logic                 advance;

    assign cur_full = {page, addr_q};
    assign nxt_full = cur_full + VADDR_W'(1);
    assign advance  = data_wr || data_rd;
    assign page_we  = advance && (&addr_q);
    assign page_val = nxt_full[VADDR_W-1:ADDR_LO_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            latch_q <= '0;
            rdata_q <= '0;
            req_q   <= 1'b0;
            op_q    <= '0;
        end else begin
            if (req_q && vram_ack) begin
                req_q <= 1'b0;
                if (!op_q.we) latch_q <= vram_rdata;
            end
            if (set_op == OP_SET_WRITE) begin
                addr_q <= set_addr;
            end
            if (set_op == OP_SET_READ) begin
                addr_q     <= set_addr;
                req_q      <= 1'b1;
                op_q.we    <= 1'b0;
                op_q.addr  <= {page, set_addr};
                op_q.data  <= '0;
            end
            if (data_wr) begin
                req_q      <= 1'b1;
                op_q.we    <= 1'b1;
                op_q.addr  <= cur_full;
                op_q.data  <= wdata;
                latch_q    <= wdata;
                addr_q     <= nxt_full[ADDR_LO_W-1:0];
            end
            if (data_rd) begin
                rdata_q    <= latch_q;
                req_q      <= 1'b1;
                op_q.we    <= 1'b0;
                op_q.addr  <= nxt_full;
                op_q.data  <= '0;
                addr_q     <= nxt_full[ADDR_LO_W-1:0];
            end
            if (ctl_rd) rdata_q <= '0;
        end
    end

    assign cpu_rdata = rdata_q;
    assign vram_req  = req_q;
    assign vram_op   = op_q;

    // R10: request held with stable fields until acknowledged
    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (req_q && !vram_ack) |=> (req_q && $stable(op_q)));

    // R10: acknowledge only arrives against an outstanding request
    p_ack_valid_r10: assert property (@(posedge clk) disable iff (rst)
        vram_ack |-> req_q);

    // R6: a data write raises a write request
    p_write_req_r6: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> (req_q && op_q.we));

    // R8: in-page address wraps to zero on the carry
    p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (advance && (&addr_q)) |=> addr_q == '0);

endmodule

// File: rtl/vdp_host_port.sv
module vdp_host_port
    import vdp_hp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_wr,
    input  logic                 cpu_rd,
    input  logic                 cpu_sel_data,
    input  logic [DATA_W-1:0]    cpu_wdata,
    output logic [DATA_W-1:0]    cpu_rdata,
    output logic                 cpu_busy,
    output logic                 vram_req,
    output logic                 vram_we,
    output logic [VADDR_W-1:0]   vram_addr,
    output logic [DATA_W-1:0]    vram_wdata,
    input  logic                 vram_ack,
    input  logic [DATA_W-1:0]    vram_rdata,
    input  logic [REG_SEL_W-1:0] cfg_rd_sel,
    output logic [DATA_W-1:0]    cfg_rd_data
);

    logic        wr_ok, rd_ok;
    logic        ctl_wr_acc, ctl_rd_acc, data_wr_acc, data_rd_acc;
    ctl_cmd_t    cmd;
    logic        page_we;
    logic [PAGE_W-1:0] page_val, page;
    vram_op_t    vop;

    assign wr_ok       = cpu_wr && !cpu_busy;
    assign rd_ok       = cpu_rd && !cpu_wr && !cpu_busy;
    assign ctl_wr_acc  = wr_ok && !cpu_sel_data;
    assign data_wr_acc = wr_ok &&  cpu_sel_data;
    assign ctl_rd_acc  = rd_ok && !cpu_sel_data;
    assign data_rd_acc = rd_ok &&  cpu_sel_data;

    vdp_ctl_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_acc    (ctl_wr_acc),
        .seq_clear (ctl_rd_acc || data_wr_acc || data_rd_acc),
        .wdata     (cpu_wdata),
        .cmd       (cmd)
    );

    vdp_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .cmd_we   (cmd.op == OP_REG_WRITE),
        .cmd_num  (cmd.reg_num),
        .cmd_val  (cmd.value),
        .page_we  (page_we),
        .page_val (page_val),
        .rd_sel   (cfg_rd_sel),
        .rd_data  (cfg_rd_data),
        .page     (page)
    );

    vdp_vram_port u_port (
        .clk        (clk),
        .rst        (rst),
        .set_op     (cmd.op),
        .set_addr   (cmd.addr),
        .data_wr    (data_wr_acc),
        .data_rd    (data_rd_acc),
        .ctl_rd     (ctl_rd_acc),
        .wdata      (cpu_wdata),
        .page       (page),
        .page_we    (page_we),
        .page_val   (page_val),
        .cpu_rdata  (cpu_rdata),
        .vram_req   (vram_req),
        .vram_op    (vop),
        .vram_ack   (vram_ack),
        .vram_rdata (vram_rdata)
    );

    assign cpu_busy   = vram_req;
    assign vram_we    = vop.we;
    assign vram_addr  = vop.addr;
    assign vram_wdata = vop.data;

    // R11: a data strobe while busy does not start a new request at the next edge
    p_busy_drop_r11: assert property (@(posedge clk) disable iff (rst)
        (cpu_busy && vram_ack) |=> !vram_req);

endmodule

// File: tb/sim_vdp_host_port.sv
module sim_vdp_host_port;
    import vdp_hp_pkg::*;

    localparam int LAT = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, cpu_wr, cpu_rd, cpu_sel_data, cpu_busy;
    logic [7:0] cpu_wdata, cpu_rdata, vram_wdata, vram_rdata, cfg_rd_data;
    logic vram_req, vram_we, vram_ack;
    logic [16:0] vram_addr;
    logic [5:0] cfg_rd_sel;

    vdp_host_port u0 (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] mem [int];
    logic [7:0] m_regs [int];
    logic [7:0] m_latch;
    int m_addr, m_page;

    typedef struct { bit we; int addr; int data; } txn_t;
    txn_t exp_q[$];

    function automatic logic [7:0] mem_rd(int a);
        if (mem.exists(a)) return mem[a];
        return 8'((a * 7 + 3) & 255);
    endfunction

    function automatic bit reg_exists(int n);
        return (n < 27) || (n >= 32 && n <= 46);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // VRAM model with fixed latency and transaction comparison
    int cnt = 0;
    always @(posedge clk) begin
        if (rst) begin
            vram_ack <= 1'b0; cnt = 0;
        end else if (vram_ack) begin
            vram_ack <= 1'b0; cnt = 0;
        end else if (vram_req) begin
            if (cnt == LAT - 1) begin
                txn_t e;
                vram_ack <= 1'b1;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R10 unexpected request actual %0h expected none", vram_addr);
                end else begin
                    e = exp_q.pop_front();
                    if (e.we !== vram_we || e.addr !== int'(vram_addr) ||
                        (e.we && e.data !== int'(vram_wdata))) begin
                        errors++;
                        $display("FAIL R6/R7 request actual we%0b %0h/%0h expected we%0b %0h/%0h",
                                 vram_we, vram_addr, vram_wdata, e.we, e.addr, e.data);
                    end
                end
                if (vram_we) mem[int'(vram_addr)] = vram_wdata;
                else vram_rdata <= mem_rd(int'(vram_addr));
            end else cnt++;
        end
    end

    // R10 per-cycle hold check
    logic p_req, p_we; logic [16:0] p_addr; logic [7:0] p_wd; logic p_ack;
    always @(posedge clk) begin
        if (!rst && p_req && !p_ack) begin
            checks++;
            if (!vram_req || vram_we !== p_we || vram_addr !== p_addr || vram_wdata !== p_wd) begin
                errors++;
                $display("FAIL R10 request changed actual %0h expected %0h", vram_addr, p_addr);
            end
        end
        if (!rst) begin
            checks++;
            if (cpu_busy !== vram_req) begin
                errors++;
                $display("FAIL R10 busy actual %0b expected %0b", cpu_busy, vram_req);
            end
        end
        p_req = vram_req; p_we = vram_we; p_addr = vram_addr; p_wd = vram_wdata; p_ack = vram_ack;
    end

    task automatic strobe(bit wr, bit sel, logic [7:0] d);
        @(negedge clk);
        cpu_wr = wr; cpu_rd = !wr; cpu_sel_data = sel; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 0; cpu_rd = 0;
    endtask

    task automatic wait_idle();
        while (cpu_busy) @(negedge clk);
    endtask

    task automatic advance();
        m_addr++;
        if (m_addr == 16384) begin
            m_addr = 0;
            m_page = (m_page + 1) % 8;
            m_regs[14] = 8'(m_page);
        end
    endtask

    task automatic reg_write(int n, logic [7:0] v);
        if (reg_exists(n)) begin
            m_regs[n] = (n == 14) ? (v & 8'h07) : v;
            if (n == 14) m_page = v & 7;
        end
        strobe(1, 0, v); wait_idle();
        strobe(1, 0, 8'h80 | 8'(n)); wait_idle();
    endtask

    task automatic chk_reg(string req, int n);
        logic [7:0] e;
        e = (reg_exists(n) && m_regs.exists(n)) ? m_regs[n] : 8'h00;
        cfg_rd_sel = 6'(n);
        #1;
        chk(req, cfg_rd_data, e);
    endtask

    task automatic set_write(int a);
        m_addr = a;
        strobe(1, 0, 8'(a)); wait_idle();
        strobe(1, 0, 8'h40 | 8'(a >> 8));
        chk("R4 no request on write setup", cpu_busy, 0);
        wait_idle();
    endtask

    task automatic set_read(int a);
        txn_t t;
        m_addr = a;
        t.we = 0; t.addr = m_page * 16384 + a; t.data = 0;
        strobe(1, 0, 8'(a)); wait_idle();
        exp_q.push_back(t);
        strobe(1, 0, 8'((a >> 8) & 8'h3F));
        chk("R5 read setup request", cpu_busy, 1);
        wait_idle();
        m_latch = mem_rd(t.addr);
    endtask

    task automatic data_write(logic [7:0] d);
        txn_t t;
        t.we = 1; t.addr = m_page * 16384 + m_addr; t.data = d;
        exp_q.push_back(t);
        m_latch = d;
        advance();
        strobe(1, 1, d); wait_idle();
    endtask

    task automatic data_read(string req);
        txn_t t;
        logic [7:0] e;
        e = m_latch;
        advance();
        t.we = 0; t.addr = m_page * 16384 + m_addr; t.data = 0;
        exp_q.push_back(t);
        strobe(0, 1, 8'h00);
        chk(req, cpu_rdata, e);
        wait_idle();
        m_latch = mem_rd(t.addr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; cpu_wr = 0; cpu_rd = 0; cpu_sel_data = 0; cpu_wdata = 0;
        cfg_rd_sel = 0; vram_rdata = 0;
        m_addr = 0; m_page = 0; m_latch = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", cpu_rdata, 0);
        chk("R1 busy", cpu_busy, 0);
        chk("R1 req", vram_req, 0);
        chk_reg("R1 reg7", 7);
        chk_reg("R1 reg14", 14);

        // R2 register writes, existing and missing numbers
        reg_write(7, 8'hA5);  chk_reg("R2 reg7", 7);
        reg_write(32, 8'h3C); chk_reg("R2 reg20h", 32);
        reg_write(46, 8'h11); chk_reg("R2 reg2Eh", 46);
        reg_write(26, 8'h42); chk_reg("R2 reg26", 26);
        reg_write(27, 8'h99); reg_write(31, 8'h98); reg_write(47, 8'h97);
        for (int n = 0; n < 64; n++) chk_reg("R2 unaffected", n);

        // R3 page mask
        reg_write(14, 8'hFD); chk_reg("R3 page masked", 14);

        // R4/R6 write setup and writes at page 5
        set_write(16'h1234);
        data_write(8'h5A);
        data_write(8'h6B);

        // R5/R7 read back through the read-ahead latch
        set_read(16'h1234);
        data_read("R7 first read");
        data_read("R7 second read");
        data_read("R7 third read");

        // R6 a write after a read setup updates the latch
        set_read(16'h2000);
        data_write(8'h77);
        set_read(16'h2000);
        data_read("R6 written byte");

        // R8 carry into the page, modulo 8
        reg_write(14, 8'h07);
        set_write(16'h3FFF);
        data_write(8'hEE);
        chk_reg("R8 page wrap", 14);
        data_write(8'hDD);
        set_read(16'h3FFF);
        data_read("R8 read crossing");
        chk_reg("R8 page after read", 14);
        data_read("R8 next page byte");

        // R9 sequencer reset by data access
        strobe(1, 0, 8'h55); wait_idle();
        data_read("R9 data read");
        reg_write(3, 8'h66); chk_reg("R9 reg3 after data read", 3);
        // R9/R12 sequencer reset by control read
        strobe(1, 0, 8'h12); wait_idle();
        strobe(0, 0, 8'h00);
        chk("R12 control read data", cpu_rdata, 0);
        reg_write(4, 8'h21); chk_reg("R9 reg4 after control read", 4);

        // R11 strobe while busy dropped
        reg_write(14, 8'h00);
        set_write(16'h0100);
        begin
            txn_t t;
            t.we = 1; t.addr = 16'h0100; t.data = 8'hA1;
            exp_q.push_back(t);
            m_latch = 8'hA1; advance();
            @(negedge clk); cpu_wr = 1; cpu_sel_data = 1; cpu_wdata = 8'hA1;
            @(negedge clk); cpu_wdata = 8'hB2;
            @(negedge clk); cpu_wr = 0;
            wait_idle();
        end
        set_read(16'h0100);
        data_read("R11 first byte kept");
        data_read("R11 dropped write absent");

        repeat (5) @(negedge clk);
        chk("R10 no stray requests", exp_q.size(), 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule